// File: doc/BRIEF.md
# Boot Mode Unlock Guard

This block protects a privileged boot mode behind an eight-byte key. It watches the write strobes of a register bus. Trigger writes go to one address and carry one byte each. Only when the eight key bytes arrive on that address, in order and one after another, does the block raise its boot-enable output. Downstream logic uses that output to gate access to flash programming and device configuration.

Each time the key is accepted, the block emits a one-cycle entry pulse. Boot mode lasts until software writes a control register with its exit bit set. That write produces a one-cycle exit pulse, drops boot-enable and discards any partial key progress.

A wrong byte clears the progress, with one exception: if the wrong byte is itself the first key byte, it is counted as the start of a new attempt. Writes to any other address, and cycles without a write strobe, leave the progress untouched. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `boot_unlock_guard`

## Requirements
- R1: While `rst_ni` is low, `boot_en_o`, `enter_pulse_o` and `exit_pulse_o` are 0. Any partial key progress is lost, so a complete key is needed after reset.
- R2: The key is the bytes 0xDE, 0xAD, 0xBE, 0xEF, 0xCA, 0xFE, 0xBA, 0xBE, written in that order. The first byte is bits 63:56 of parameter `KEY`. Each byte is a write of `wr_data_i` to address `TRIG_ADDR` (default 4'h3). `boot_en_o` goes to 1 on the clock edge that registers the eighth correct write.
- R3: `enter_pulse_o` is 1 for exactly one cycle, the same cycle in which `boot_en_o` first shows 1.
- R4: A trigger byte that does not match the expected key byte discards the progress. If that byte equals the first key byte (0xDE), it counts as key position one.
- R5: Writes to addresses other than `TRIG_ADDR` and `CTRL_ADDR`, and cycles with `wr_en_i` low, change neither the key progress nor any output.
- R6: A write to `CTRL_ADDR` (default 4'h2) with bit `EXIT_BIT` (default 0) set gives a one-cycle `exit_pulse_o` on the next edge. It clears `boot_en_o` in that same cycle and discards any partial key progress.
- R7: A write to `CTRL_ADDR` with bit `EXIT_BIT` clear has no effect.
- R8: While boot mode is active, trigger writes are ignored. They give no new entry pulse and build no progress, so a fresh full key is needed after an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| boot_en_o | output | 1 | Boot mode active; gates flash and configuration access |
| enter_pulse_o | output | 1 | One-cycle pulse when boot mode is entered |
| exit_pulse_o | output | 1 | One-cycle pulse on an exit command |

## Verification
The bound checker watches every cycle for several properties:
- the entry pulse is a single cycle and coincides with boot-enable;
- boot-enable rises only after a trigger write of the final key byte, and falls only after an exit command;
- the entry pulse never fires while boot mode is already active;
- idle cycles and control writes without the exit bit leave the outputs alone.

Other behaviour can only be shown by the bench's write sequences. These cover the full ordered key, mismatch recovery (including a repeated first byte), interleaved foreign writes, the loss of progress on exit and on reset, and the ignoring of trigger writes inside boot mode.

// File: rtl/boot_unlock_pkg.sv
package boot_unlock_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_TRIG = 2'd1,
    WR_EXIT = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/boot_write_decoder.sv
module boot_write_decoder
  import boot_unlock_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h2,
  parameter int              EXIT_BIT  = 0
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output wr_kind_e          kind_o
);
  // Classify the current bus write; control writes without the exit bit are inert (R7).
  always_comb begin
    kind_o = WR_NONE;
    if (wr_en_i) begin
      if (wr_addr_i == TRIG_ADDR) begin
        kind_o = WR_TRIG;
      end else if ((wr_addr_i == CTRL_ADDR) && wr_data_i[EXIT_BIT]) begin
        kind_o = WR_EXIT;
      end
    end
  end
endmodule

// File: rtl/boot_seq_tracker.sv
module boot_seq_tracker
  import boot_unlock_pkg::*;
#(
  parameter int                     KEY_LEN = 8,
  parameter logic [KEY_LEN*8-1:0]   KEY     = 64'hDEAD_BEEF_CAFE_BABE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o
);
  localparam int                 CNT_W = $clog2(KEY_LEN);
  localparam logic [CNT_W-1:0]   LAST  = CNT_W'(KEY_LEN - 1);
  localparam logic [CNT_W-1:0]   ONE   = CNT_W'(1);

  logic [BYTE_W-1:0] key_bytes [KEY_LEN];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hit, restart;

  // Byte g of the key sits at the g-th most significant byte of KEY.
  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign key_bytes[g] = KEY[(KEY_LEN-1-g)*BYTE_W +: BYTE_W];
  end

  assign hit     = (byte_i == key_bytes[cnt_q]);
  assign restart = (byte_i == key_bytes[0]);

  always_comb begin
    cnt_d  = cnt_q;
    done_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (trig_i) begin
      if (hit) begin
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          done_o = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        cnt_d = restart ? ONE : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (trig_i || clr_i) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/boot_mode_reg.sv
module boot_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic boot_en_o,
  output logic enter_pulse_o,
  output logic exit_pulse_o
);
  logic en_q, en_d, ent_q, ext_q;

  always_comb begin
    en_d = en_q;
    if (clr_i) begin
      en_d = 1'b0;
    end else if (set_i) begin
      en_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ent_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      ent_q <= set_i && !clr_i;
      ext_q <= clr_i;
    end
  end

  assign boot_en_o     = en_q;
  assign enter_pulse_o = ent_q;
  assign exit_pulse_o  = ext_q;
endmodule

// File: rtl/boot_unlock_guard.sv
module boot_unlock_guard
  import boot_unlock_pkg::*;
#(
  parameter int                   ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    TRIG_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR = 4'h2,
  parameter int                   EXIT_BIT  = 0,
  parameter int                   KEY_LEN   = 8,
  parameter logic [KEY_LEN*8-1:0] KEY       = 64'hDEAD_BEEF_CAFE_BABE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              boot_en_o,
  output logic              enter_pulse_o,
  output logic              exit_pulse_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  wr_kind_e   kind;
  logic       trig_go, exit_go, key_done;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  boot_write_decoder #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR),
    .CTRL_ADDR(CTRL_ADDR),
    .EXIT_BIT (EXIT_BIT)
  ) u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .kind_o   (kind)
  );

  // Trigger writes are ignored while boot mode is active (R8).
  assign trig_go = (kind == WR_TRIG) && !boot_en_o;
  assign exit_go = (kind == WR_EXIT);

  boot_seq_tracker #(
    .KEY_LEN(KEY_LEN),
    .KEY    (KEY)
  ) u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .trig_i(trig_go),
    .clr_i (exit_go),
    .byte_i(wr_data_i),
    .done_o(key_done)
  );

  boot_mode_reg u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .set_i        (key_done),
    .clr_i        (exit_go),
    .boot_en_o    (boot_en_o),
    .enter_pulse_o(enter_pulse_o),
    .exit_pulse_o (exit_pulse_o)
  );
endmodule

module boot_unlock_guard_chk #(
  parameter int                   ADDR_W    = 4,
  parameter logic [ADDR_W-1:0]    TRIG_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR = 4'h2,
  parameter int                   EXIT_BIT  = 0,
  parameter int                   KEY_LEN   = 8,
  parameter logic [KEY_LEN*8-1:0] KEY       = 64'hDEAD_BEEF_CAFE_BABE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              boot_en_o,
  input logic              enter_pulse_o,
  input logic              exit_pulse_o
);
  assert_enter_with_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_pulse_o |-> boot_en_o);

  assert_enter_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_pulse_o |=> !enter_pulse_o);

  assert_rise_after_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(boot_en_o) |-> ($past(wr_en_i) && ($past(wr_addr_i) == TRIG_ADDR)
                          && ($past(wr_data_i) == KEY[7:0])));

  assert_fall_on_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boot_en_o) |-> ($past(wr_en_i) && ($past(wr_addr_i) == CTRL_ADDR)
                          && $past(wr_data_i[EXIT_BIT])));

  assert_exit_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_pulse_o |-> !boot_en_o);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(boot_en_o) && !enter_pulse_o && !exit_pulse_o));

  assert_ctrl_inert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == CTRL_ADDR) && !wr_data_i[EXIT_BIT])
      |=> ($stable(boot_en_o) && !exit_pulse_o && !enter_pulse_o));

  assert_no_reentry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_pulse_o |-> !$past(boot_en_o));
endmodule

bind boot_unlock_guard boot_unlock_guard_chk #(
  .ADDR_W   (ADDR_W),
  .TRIG_ADDR(TRIG_ADDR),
  .CTRL_ADDR(CTRL_ADDR),
  .EXIT_BIT (EXIT_BIT),
  .KEY_LEN  (KEY_LEN),
  .KEY      (KEY)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .boot_en_o    (boot_en_o),
  .enter_pulse_o(enter_pulse_o),
  .exit_pulse_o (exit_pulse_o)
);

// File: tb/boot_unlock_guard_test.sv
`timescale 1ns/1ps
module boot_unlock_guard_test;
  localparam logic [3:0] TRIG = 4'h3;
  localparam logic [3:0] CTRL = 4'h2;
  localparam logic [3:0] OTHR = 4'h5;

  logic       clk;
  logic       rst_ni;
  logic       wr_en_i;
  logic [3:0] wr_addr_i;
  logic [7:0] wr_data_i;
  logic       boot_en_o, enter_pulse_o, exit_pulse_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [7:0] key [8] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hCA, 8'hFE, 8'hBA, 8'hBE};

  int m_cnt;
  bit m_en;

  string      tag_q [$];
  logic [2:0] exp_q [$];

  boot_unlock_guard uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .boot_en_o    (boot_en_o),
    .enter_pulse_o(enter_pulse_o),
    .exit_pulse_o (exit_pulse_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual {en,enter,exit}=%b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: compares the registered outputs shortly after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), {boot_en_o, enter_pulse_o, exit_pulse_o}, exp_q.pop_front());
    end
  end

  // Driver: one bus cycle, with the expected result predicted from the requirements.
  task automatic step(input bit en, input logic [3:0] a, input logic [7:0] d, input string tag);
    bit e_ent = 0;
    bit e_ext = 0;
    @(negedge clk);
    wr_en_i   = en;
    wr_addr_i = a;
    wr_data_i = d;
    if (en && a == TRIG && !m_en) begin
      if (d == key[m_cnt]) begin
        if (m_cnt == 7) begin
          m_cnt = 0;
          m_en  = 1;
          e_ent = 1;
        end else begin
          m_cnt++;
        end
      end else begin
        m_cnt = (d == key[0]) ? 1 : 0;
      end
    end else if (en && a == CTRL && d[0]) begin
      e_ext = 1;
      m_en  = 0;
      m_cnt = 0;
    end
    tag_q.push_back(tag);
    exp_q.push_back({m_en, e_ent, e_ext});
  endtask

  task automatic idle(input string tag);
    step(0, TRIG, 8'h00, tag);
  endtask

  task automatic send_key(input int from, input string tag);
    for (int i = from; i < 8; i++) step(1, TRIG, key[i], tag);
  endtask

  task automatic do_exit(input string tag);
    step(1, CTRL, 8'h01, tag);
    idle(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en_i = 0;
    rst_ni  = 0;
    #0.5;
    check("R1 outputs low in reset", {boot_en_o, enter_pulse_o, exit_pulse_o}, 3'b000);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    m_cnt  = 0;
    m_en   = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!ended) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; wr_en_i = 0; wr_addr_i = '0; wr_data_i = '0;
    m_cnt = 0; m_en = 0;
    do_reset();

    // R2/R3: full key enters boot mode, one-cycle entry pulse
    send_key(0, "R2 R3 key entry");
    idle("R3 entry pulse ends");
    // R8: key written again while active is ignored
    send_key(0, "R8 trigger ignored in boot mode");
    // R7: control write without exit bit
    step(1, CTRL, 8'hFE, "R7 control without exit bit");
    idle("R7 still active");
    // R6: exit
    do_exit("R6 exit");

    // R5: foreign writes and idle cycles inside the key
    step(1, TRIG, 8'hDE, "R5 key byte");
    step(1, TRIG, 8'hAD, "R5 key byte");
    step(1, OTHR, 8'h00, "R5 other address");
    step(0, TRIG, 8'h00, "R5 strobe low");
    step(1, CTRL, 8'h00, "R5 R7 control no exit");
    send_key(2, "R5 key completes");
    do_exit("R6 exit after R5");

    // R4: wrong byte discards progress
    step(1, TRIG, 8'hDE, "R4 start");
    step(1, TRIG, 8'hAD, "R4 start");
    step(1, TRIG, 8'h00, "R4 wrong byte");
    send_key(2, "R4 tail after mismatch no entry");
    // R4: repeated first byte counts as position one
    step(1, TRIG, 8'hDE, "R4 first");
    step(1, TRIG, 8'hDE, "R4 DE restart");
    send_key(1, "R4 completes from restart");
    do_exit("R6 exit after R4");

    // R6: exit discards partial progress
    send_key(5, "R6 partial tail no entry");
    step(1, TRIG, 8'hDE, "R6 partial");
    step(1, TRIG, 8'hAD, "R6 partial");
    step(1, TRIG, 8'hBE, "R6 partial");
    do_exit("R6 exit clears progress");
    send_key(3, "R6 tail after exit no entry");

    // R1: reset in boot mode and mid-key
    send_key(0, "R1 setup");
    idle("R1 setup");
    do_reset();
    step(1, TRIG, 8'hDE, "R1 partial");
    step(1, TRIG, 8'hAD, "R1 partial");
    step(1, TRIG, 8'hBE, "R1 partial");
    idle("R1 partial");
    do_reset();
    send_key(3, "R1 tail after reset no entry");
    send_key(0, "R1 full key after reset");
    do_exit("R6 final exit");
    idle("final");
    @(negedge clk);
    @(negedge clk);

    ended = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule